// File: doc/BRIEF.md
# GPIO Port With Bulk Pin Configuration

This block is a 32-pin general-purpose I/O port attached to a simple single-cycle register bus. Software steers every pin through a direction register and an output register. Each of those two registers has plain-write, set, clear and toggle addresses, so a single bus write can change any chosen group of pins without a read-modify-write. Pad levels come back through a two-flop synchroniser into a readable input register, gated by each pin's input enable.

Each pin has a small configuration byte with three controls:
- input-buffer enable
- pull enable
- peripheral-routing enable

Each pair of pins shares a byte that selects the peripheral function, one nibble per pin. A write-only bulk configuration register copies one configuration pattern onto as many as sixteen masked pins of either half of the port in a single write. Configuration bytes and function bytes can also be read and written one at a time.

The bus has no back-pressure. A write strobe is always accepted in the cycle it is high. Read data is a combinational function of the address, so an address presented in a cycle returns its data in that same cycle. This block has no streaming data path, so every pin is a plain level.

Top module: `pinbank_port`

## Requirements
- R1: After reset every register reads zero. At the pads, `pad_oe`, `pad_pull_en`, `pad_mux_en` and `pad_func` are all zero.
- R2: The direction register is written at 0x00 (plain write), 0x01 (clear), 0x02 (set) and 0x03 (toggle), and is read at 0x00. In the alias writes, a 1 in the data acts on that pin and a 0 leaves it unchanged.
- R3: The output register works the same way at 0x04 (plain write), 0x05 (clear), 0x06 (set) and 0x07 (toggle), and is read at 0x04.
- R4: The input register is read at 0x08. A pad level shows there after the second rising clock edge following its change. A bit reads 0 while that pin's input enable is clear. Writes to 0x08 are ignored.
- R5: The bulk register is at 0x09 and has these fields:
  - bits [15:0]: pin mask
  - bit 16: input enable
  - bit 17: pull enable
  - bit 18: routing enable
  - bit 24: write-config
  - bit 31: half select (0 = pins 0..15, 1 = pins 16..31)
  
  When write-config is 1, the three field bits are copied into every masked pin of the selected half. All other pins are unchanged.
- R6: A bulk write with write-config 0 changes no pin configuration.
- R7: Address 0x09 always reads zero.
- R8: `pad_pull_en[p]` is 1 only when pull enable is set, the pin is an input and routing is off. `pad_pull_up[p]` is then the output-register bit: 1 selects pull-up and 0 selects pull-down.
- R9: The function byte for pins 2k and 2k+1 is at 0x20+k and holds pin 2k in bits [3:0] and pin 2k+1 in bits [7:4]. `pad_func[4p+3:4p]` presents pin p's nibble.
- R10: When routing enable is set, `pad_mux_en[p]` is 1, and `pad_oe[p]` and `pad_pull_en[p]` are forced to 0.
- R11: The configuration byte of pin p is at 0x40+p, with bit 0 = routing enable, bit 1 = input enable and bit 2 = pull enable. Other bits read zero. Any write takes effect at the clock edge that samples the strobe and can be read in the following cycle. With no write strobe, no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 7 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, same cycle |
| pad_in | input | 32 | Raw pad levels (asynchronous) |
| pad_oe | output | 32 | Output driver enable per pin |
| pad_out | output | 32 | Output register value per pin |
| pad_pull_en | output | 32 | Pull resistor enable per pin |
| pad_pull_up | output | 32 | Pull direction, 1 = up |
| pad_mux_en | output | 32 | Pin handed to its peripheral function |
| pad_func | output | 128 | Four-bit function select per pin |

## Verification
A corrupted direction or output bit shows up immediately on `pad_oe`, `pad_out` and `pad_pull_up`. It is also visible on the very next read of the register. A wrong bulk decode (a pin from the wrong half, or a mask bit off by one) leaves a neighbouring pin's configuration byte altered. That error only appears when the byte is read back, or when that pin's pull or routing state is observed. A synchroniser with the wrong depth is seen as the input register changing one edge early or one edge late, so the bench samples at exactly the second edge.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  // Register addresses (word addresses on the 7-bit bus)
  localparam int A_DIR  = 0;   // +0 write, +1 clear, +2 set, +3 toggle
  localparam int A_OUT  = 4;
  localparam int A_IN   = 8;
  localparam int A_BULK = 9;
  localparam int A_MUX  = 32;  // one byte per pin pair
  localparam int A_CFG  = 64;  // one byte per pin

  // Alias offsets inside a four-address group
  localparam logic [1:0] OFF_WR  = 2'd0;
  localparam logic [1:0] OFF_CLR = 2'd1;
  localparam logic [1:0] OFF_SET = 2'd2;
  localparam logic [1:0] OFF_TGL = 2'd3;

  // Bulk register fields
  localparam int BK_IN    = 16;
  localparam int BK_PULL  = 17;
  localparam int BK_MUX   = 18;
  localparam int BK_WRCFG = 24;
  localparam int BK_HALF  = 31;

  localparam int CFG_W  = 3;
  localparam int FUNC_W = 4;

  typedef struct packed {
    logic pull_en;  // bit 2
    logic in_en;    // bit 1
    logic mux_en;   // bit 0
  } pin_cfg_t;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pinbank_alias_reg.sv
module pinbank_alias_reg
  import pinbank_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int BASE   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [W-1:0]      q
);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);

  logic         hit;
  logic [W-1:0] m;
  logic         unused_hi;

  assign hit       = wr_en && (addr[ADDR_W-1:2] == BASE_A[ADDR_W-1:2]);
  assign m         = wdata[W-1:0];
  assign unused_hi = ^{wdata, BASE_A[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (hit) begin
      case (addr[1:0])
        OFF_WR:  q <= m;
        OFF_CLR: q <= q & ~m;
        OFF_SET: q <= q | m;
        default: q <= q ^ m;
      endcase
    end
  end
endmodule

// File: rtl/pinbank_cfg.sv
module pinbank_cfg
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  output pin_cfg_t [NPINS-1:0] cfg
);
  localparam int HALF = NPINS / 2;

  logic     bulk_go;
  logic     upper;
  pin_cfg_t bulk_val;
  pin_cfg_t direct_val;
  logic     unused_w;

  assign bulk_go    = wr_en && (addr == ADDR_W'(A_BULK)) && wdata[BK_WRCFG];
  assign upper      = wdata[BK_HALF];
  assign bulk_val   = '{pull_en: wdata[BK_PULL], in_en: wdata[BK_IN], mux_en: wdata[BK_MUX]};
  assign direct_val = pin_cfg_t'(wdata[CFG_W-1:0]);
  assign unused_w   = ^wdata;

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int          LANE    = (p >= HALF) ? p - HALF : p;
    localparam logic        IS_HIGH = (p >= HALF);
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(A_CFG + p);

    logic bulk_sel;
    logic direct_sel;

    assign bulk_sel   = bulk_go && (upper == IS_HIGH) && wdata[LANE];
    assign direct_sel = wr_en && (addr == MY_A);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cfg[p] <= '0;
      else if (direct_sel) cfg[p] <= direct_val;
      else if (bulk_sel)   cfg[p] <= bulk_val;
    end
  end
endmodule

// File: rtl/pinbank_mux.sv
module pinbank_mux
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wdata,
  output logic [NPINS*FUNC_W-1:0]   func
);
  localparam int NPAIRS = NPINS / 2;

  logic unused_w;
  assign unused_w = ^wdata[DATA_W-1:8];

  for (genvar k = 0; k < NPAIRS; k++) begin : g_pair
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(A_MUX + k);
    logic [7:0] sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         sel_q <= '0;
      else if (wr_en && (addr == MY_A))   sel_q <= wdata[7:0];
    end

    // even pin takes the low nibble, odd pin the high nibble
    assign func[(2*k)*FUNC_W   +: FUNC_W] = sel_q[3:0];
    assign func[(2*k+1)*FUNC_W +: FUNC_W] = sel_q[7:4];
  end
endmodule

// File: rtl/pinbank_port.sv
module pinbank_port
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [DATA_W-1:0]       wdata,
  output logic [DATA_W-1:0]       rdata,
  input  logic [NPINS-1:0]        pad_in,
  output logic [NPINS-1:0]        pad_oe,
  output logic [NPINS-1:0]        pad_out,
  output logic [NPINS-1:0]        pad_pull_en,
  output logic [NPINS-1:0]        pad_pull_up,
  output logic [NPINS-1:0]        pad_mux_en,
  output logic [NPINS*FUNC_W-1:0] pad_func
);
  localparam int PIDX_W = $clog2(NPINS);
  localparam int NPAIRS = NPINS / 2;

  logic [NPINS-1:0]       dir_q;
  logic [NPINS-1:0]       out_q;
  logic [NPINS-1:0]       in_sync;
  pin_cfg_t [NPINS-1:0]   cfg;
  logic [NPINS*CFG_W-1:0] cfg_flat;
  logic [NPINS-1:0]       v_in, v_pull, v_mux;
  logic [ADDR_W-1:0]      off_cfg, off_mux;
  logic                   unused_off;

  pinbank_alias_reg #(.W(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(A_DIR)) u_dir (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .q(dir_q));

  pinbank_alias_reg #(.W(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE(A_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .q(out_q));

  pinbank_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(in_sync));

  pinbank_cfg #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .cfg(cfg));

  pinbank_mux #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .func(pad_func));

  for (genvar p = 0; p < NPINS; p++) begin : g_split
    assign v_in[p]   = cfg[p].in_en;
    assign v_pull[p] = cfg[p].pull_en;
    assign v_mux[p]  = cfg[p].mux_en;
    assign cfg_flat[p*CFG_W +: CFG_W] = cfg[p];
  end

  // Pad side
  assign pad_out     = out_q;
  assign pad_mux_en  = v_mux;
  assign pad_oe      = dir_q & ~v_mux;
  assign pad_pull_en = v_pull & ~dir_q & ~v_mux;
  assign pad_pull_up = pad_pull_en & out_q;

  // Read side
  assign off_cfg    = addr - ADDR_W'(A_CFG);
  assign off_mux    = addr - ADDR_W'(A_MUX);
  assign unused_off = ^{off_cfg, off_mux};

  always_comb begin
    rdata = '0;
    if (addr >= ADDR_W'(A_CFG) && addr < ADDR_W'(A_CFG + NPINS)) begin
      rdata = DATA_W'(cfg[off_cfg[PIDX_W-1:0]]);
    end else if (addr >= ADDR_W'(A_MUX) && addr < ADDR_W'(A_MUX + NPAIRS)) begin
      rdata = DATA_W'(pad_func[off_mux[PIDX_W-2:0]*8 +: 8]);
    end else if (addr == ADDR_W'(A_DIR)) begin
      rdata = DATA_W'(dir_q);
    end else if (addr == ADDR_W'(A_OUT)) begin
      rdata = DATA_W'(out_q);
    end else if (addr == ADDR_W'(A_IN)) begin
      rdata = DATA_W'(in_sync & v_in);
    end
  end
endmodule

// File: rtl/pinbank_port_chk.sv
module pinbank_port_chk
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       addr,
  input logic [DATA_W-1:0]       wdata,
  input logic [NPINS-1:0]        dir_q,
  input logic [NPINS-1:0]        out_q,
  input logic [NPINS*CFG_W-1:0]  cfg_flat,
  input logic [NPINS*FUNC_W-1:0] pad_func
);
  // R2
  dir_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_DIR + 2)) |=> dir_q == ($past(dir_q) | $past(wdata[NPINS-1:0])));

  // R3
  out_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_OUT + 3)) |=> out_q == ($past(out_q) ^ $past(wdata[NPINS-1:0])));

  // R6
  bulk_nocfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_BULK) && !wdata[BK_WRCFG]) |=> $stable(cfg_flat));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dir_q) && $stable(out_q) && $stable(cfg_flat)));

  // R9
  func_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(A_MUX)) |=>
      (pad_func[3:0] == $past(wdata[3:0]) && pad_func[7:4] == $past(wdata[7:4])));
endmodule

bind pinbank_port pinbank_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .dir_q(dir_q), .out_q(out_q), .cfg_flat(cfg_flat), .pad_func(pad_func));

// File: tb/pinbank_port_test.sv
module pinbank_port_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [6:0]   addr = '0;
  logic [31:0]  wdata = '0;
  logic [31:0]  rdata;
  logic [31:0]  pad_in = '0;
  logic [31:0]  pad_oe, pad_out, pad_pull_en, pad_pull_up, pad_mux_en;
  logic [127:0] pad_func;

  int  nchk = 0;
  int  nfail = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  pinbank_port uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pull_en(pad_pull_en),
    .pad_pull_up(pad_pull_up), .pad_mux_en(pad_mux_en), .pad_func(pad_func));

  // {req[3:0], waddr[6:0], wdata[31:0], raddr[6:0], expected[31:0]}
  localparam int NV = 15;
  localparam logic [81:0] VEC [NV] = '{
    {4'd2,  7'h00, 32'h0000_00FF, 7'h00, 32'h0000_00FF},  // R2 plain write
    {4'd2,  7'h02, 32'h0000_0F00, 7'h00, 32'h0000_0FFF},  // R2 set
    {4'd2,  7'h01, 32'h0000_000F, 7'h00, 32'h0000_0FF0},  // R2 clear
    {4'd2,  7'h03, 32'h8000_0FF0, 7'h00, 32'h8000_0000},  // R2 toggle
    {4'd3,  7'h04, 32'h1234_5678, 7'h04, 32'h1234_5678},  // R3 plain write
    {4'd3,  7'h06, 32'h0000_0081, 7'h04, 32'h1234_56F9},  // R3 set
    {4'd3,  7'h05, 32'h1000_0001, 7'h04, 32'h0234_56F8},  // R3 clear
    {4'd3,  7'h07, 32'hFFFF_0000, 7'h04, 32'hFDCB_56F8},  // R3 toggle
    {4'd5,  7'h09, 32'h0103_0005, 7'h40, 32'h0000_0006},  // R5 low half, pins 0,2
    {4'd5,  7'h08, 32'hFFFF_FFFF, 7'h41, 32'h0000_0000},  // R5 unmasked pin 1 untouched
    {4'd5,  7'h09, 32'h8105_0003, 7'h50, 32'h0000_0003},  // R5 upper half, pin 16
    {4'd7,  7'h08, 32'h0000_0000, 7'h09, 32'h0000_0000},  // R7 bulk reads zero
    {4'd6,  7'h09, 32'h0007_FFFF, 7'h40, 32'h0000_0006},  // R6 no write-config
    {4'd9,  7'h23, 32'h0000_00A5, 7'h23, 32'h0000_00A5},  // R9 pair byte 3
    {4'd11, 7'h45, 32'h0000_00FF, 7'h45, 32'h0000_0007}   // R11 direct config byte
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [6:0] a, input logic [31:0] exp, input int req);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs held at zero during reset
    check(1, pad_oe | pad_pull_en | pad_mux_en, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 registers and pads zero after reset
    rd_check(7'h00, 32'h0, 1);
    rd_check(7'h04, 32'h0, 1);
    rd_check(7'h08, 32'h0, 1);
    rd_check(7'h40, 32'h0, 1);
    rd_check(7'h20, 32'h0, 1);
    check(1, pad_func[31:0] | pad_func[127:96], 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][77:71], VEC[i][70:39]);
      rd_check(VEC[i][38:32], VEC[i][31:0], int'(VEC[i][81:78]));
    end

    // R8 pull direction follows output register for inputs
    wr(7'h06, 32'h0000_0001);
    #1;
    check(8, {30'b0, pad_pull_en[0], pad_pull_up[0]}, 32'h3);
    check(8, {30'b0, pad_pull_en[2], pad_pull_up[2]}, 32'h2);
    wr(7'h02, 32'h0000_0001);  // pin 0 becomes output
    #1;
    check(8, {30'b0, pad_pull_en[0], pad_oe[0]}, 32'h1);

    // R10 routing enable overrides direction and pull
    wr(7'h02, 32'h0001_0000);
    #1;
    check(10, {29'b0, pad_oe[16], pad_mux_en[16], pad_mux_en[5]}, 32'h3);
    check(10, {31'b0, pad_pull_en[5]}, 32'h0);

    // R9 nibble placement for pins 6 and 7
    check(9, {24'b0, pad_func[31:28], pad_func[27:24]}, 32'h0000_00A5);

    // R4 two-edge synchroniser and input-enable gating
    @(negedge clk);
    pad_in = 32'h0002_0003;
    addr = 7'h08;
    @(negedge clk);
    #1;
    check(4, rdata, 32'h0);
    @(negedge clk);
    #1;
    check(4, rdata, 32'h0002_0001);
    wr(7'h08, 32'h0);  // R4 write to input register ignored
    rd_check(7'h08, 32'h0002_0001, 4);

    // R11 idle cycles hold state
    repeat (3) @(negedge clk);
    rd_check(7'h04, 32'hFDCB_56F9, 11);

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R11 watchdog expired actual=hung expected=finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule